// File: doc/BRIEF.md
# PWM Output Emergency Tristate Controller

This block decides when timer output pins must be released to high impedance. It serves two pin groups. The first is a set of complementary PWM pins arranged in pairs, and the second is a small group of single-channel timer pins. Each group has a per-pin enable mask. A pin can only be tristated if its mask bit is set.

Several shutdown sources are each latched in their own flag. A software request bit exists for each group, and an external event pulse can set either of them. An oscillator-stop indication from outside the block acts on both groups. Fault input pins are sampled at a prescaled strobe and act on both groups. An output-level comparison flags the case where both pins of a complementary pair are high at once, and it acts on the PWM group only. Software releases a source by writing to that source's flag through a simple write-only register port. Some of these clears are refused while the fault is still present or has not yet been resolved.

Register map (write-only, `wr_addr`): 0 pair-group mask; 1 solo-group mask; 2 request bits (bit0 pair group, bit1 solo group); 3 fault modes (two bits per fault input k at bits 2k+1:2k); 4 fault flag clear (bit k written 0 clears flag k, 1 leaves it); 5 comparison control (bit0 enable, bit1 written 0 requests a flag clear); 6 oscillator control (bit0 enable, bit1 written 0 requests a flag clear); 7 prescaler value.

Top module: `pwm_tz_guard`

## Requirements
- R1: Each tristate output is registered and is high only if its pin's mask bit is set and a source acting on its group is active. It follows that source one clock after the source flag changes.
- R2: Writing address 2 loads bit0 into the pair-group request. While it is 1, every masked pair pin is tristated. Writing 0 releases them.
- R3: Writing address 2 loads bit1 into the solo-group request. While it is 1, every masked solo pin is tristated. Writing 0 releases them.
- R4: A pulse on `evt_pair` or `evt_solo` sets the matching request bit. The event wins over a write of 0 to that bit in the same cycle.
- R5: Input `osc_stop` sets an oscillator flag, and it keeps the flag set while it stays high. Both groups are tristated while that flag and the oscillator enable (address 6 bit0, reset value 1) are both 1. Clearing either the flag or the enable releases the pins.
- R6: With fault mode 0, a falling edge between two successive samples of a fault pin sets that pin's fault flag.
- R7: Fault modes 1, 2 and 3 set the flag after 8, 16 and 128 consecutive low samples, respectively. A high sample restarts the count.
- R8: Any set fault flag tristates both groups. The pins are released only when every fault flag has been cleared through address 4. A hardware set wins over a same-cycle clear.
- R9: In modes 1 to 3, a clear of a fault flag is ignored unless the most recent sample of that pin was high.
- R10: When the comparison is enabled, both pins of any pair (2k, 2k+1) high at once sets the comparison flag. This flag tristates the masked pair pins and leaves the solo group unaffected.
- R11: A clear of the comparison flag is ignored while any pair-group pin level is still high.
- R12: The fault-sampling strobe fires once every (prescaler + 1) clocks.
- R13: After reset, all flags, masks, modes and the prescaler are 0, the oscillator enable is 1, and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DW (10) | Write data |
| evt_pair | input | 1 | Event pulse that sets the pair-group request |
| evt_solo | input | 1 | Event pulse that sets the solo-group request |
| osc_stop | input | 1 | Oscillator-stop indication |
| flt_n | input | N_FLT (5) | Active-low fault input pins, asynchronous |
| pair_lvl | input | N_PAIR_PINS (6) | Levels currently driven on the pair-group pins |
| tz_pair | output | N_PAIR_PINS (6) | Tristate enable per pair-group pin |
| tz_solo | output | N_SOLO_PINS (4) | Tristate enable per solo-group pin |

## Verification
The assertions check several rules on every clock. No output is raised on an unmasked pin, and a pending hardware set always reaches its flag. A blocked clear of a fault or comparison flag leaves the flag set. The strobe never fires on back-to-back clocks with a nonzero prescaler, and an event pulse always lands in its request bit. Other behaviour only the bench scenarios can show. These are the sample-count thresholds of each level mode, the restart of a count after a short low run, and the release only after the last of several fault flags is cleared. They also include the oscillator enable re-applying a still-latched flag and the refused clear while a freshly raised pin has not yet been sampled.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

  typedef enum logic [2:0] {
    A_MASK_PAIR = 3'd0,
    A_MASK_SOLO = 3'd1,
    A_SWREQ     = 3'd2,
    A_FLT_MODE  = 3'd3,
    A_FLT_CLR   = 3'd4,
    A_CMP       = 3'd5,
    A_OSC       = 3'd6,
    A_PRESC     = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    M_EDGE    = 2'd0,
    M_LOW8    = 2'd1,
    M_LOW16   = 2'd2,
    M_LOW128  = 2'd3
  } flt_mode_e;

  localparam int RUN_W = 8;

  // consecutive low samples needed before a level-mode fault trips
  function automatic logic [RUN_W-1:0] run_len(input flt_mode_e m);
    case (m)
      M_LOW8:   return RUN_W'(8);
      M_LOW16:  return RUN_W'(16);
      M_LOW128: return RUN_W'(128);
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/ptg_strobe.sv
module ptg_strobe #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] presc,
  output logic          strobe
);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else if (cnt >= presc) begin
      cnt    <= '0;
      strobe <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      strobe <= 1'b0;
    end
  end

  // R12: with a nonzero divider the strobe never fires twice in a row
  p_strobe_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && presc != '0) |=> (!strobe || presc != $past(presc)));

endmodule

// File: rtl/ptg_fault_chan.sv
module ptg_fault_chan
  import ptg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n,
  input  logic       strobe,
  input  logic [1:0] mode_raw,
  input  logic       clr_req,
  output logic       flag
);

  flt_mode_e        mode;
  logic             s1, s2, smp;
  logic [RUN_W-1:0] run;
  logic [RUN_W-1:0] thr;
  logic             edge_hit, level_hit, set_evt;
  logic             clr_ok, clr_blocked;

  assign mode = flt_mode_e'(mode_raw);
  assign thr  = run_len(mode);

  // two-flop synchroniser, idle level high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
    end
  end

  // strobe-qualified sample and saturating low-run counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp <= 1'b1;
      run <= '0;
    end else if (strobe) begin
      smp <= s2;
      if (s2)            run <= '0;
      else if (run != '1) run <= run + 1'b1;
    end
  end

  assign edge_hit  = strobe && smp && !s2 && (mode == M_EDGE);
  assign level_hit = strobe && !s2 && (mode != M_EDGE) &&
                     (({1'b0, run} + 1'b1) >= {1'b0, thr});
  assign set_evt   = edge_hit || level_hit;

  // level modes refuse a clear until a high level has actually been sampled
  assign clr_ok      = (mode == M_EDGE) || smp;
  assign clr_blocked = clr_req && !clr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag <= 1'b0;
    else if (set_evt)           flag <= 1'b1;
    else if (clr_req && clr_ok) flag <= 1'b0;
  end

  // R8: a hardware set always wins over a same-cycle clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);

  // R9: a refused clear leaves the flag standing
  p_clr_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && clr_blocked) |=> flag);

endmodule

// File: rtl/ptg_out_cmp.sv
module ptg_out_cmp #(
  parameter int NP = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NP-1:0] lvl,
  input  logic          clr_req,
  output logic          flag
);

  localparam int NPAIRS = NP / 2;

  function automatic logic pair_clash(input logic [NP-1:0] v);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < NPAIRS; k++) hit = hit | (v[2*k] & v[2*k+1]);
    return hit;
  endfunction

  logic clash, idle, clr_blocked;

  assign clash       = en && pair_clash(lvl);
  assign idle        = (lvl == '0);
  assign clr_blocked = clr_req && !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               flag <= 1'b0;
    else if (clash)           flag <= 1'b1;
    else if (clr_req && idle) flag <= 1'b0;
  end

  // R10: a detected clash always latches
  p_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> flag);

  // R11: clear refused while pins still drive an active level
  p_clr_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && clr_blocked) |=> flag);

endmodule

// File: rtl/pwm_tz_guard.sv
module pwm_tz_guard
  import ptg_pkg::*;
#(
  parameter int N_PAIR_PINS = 6,
  parameter int N_SOLO_PINS = 4,
  parameter int N_FLT       = 5,
  parameter int PRESC_W     = 8,
  parameter int DW          = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [2:0]             wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic                   evt_pair,
  input  logic                   evt_solo,
  input  logic                   osc_stop,
  input  logic [N_FLT-1:0]       flt_n,
  input  logic [N_PAIR_PINS-1:0] pair_lvl,
  output logic [N_PAIR_PINS-1:0] tz_pair,
  output logic [N_SOLO_PINS-1:0] tz_solo
);

  localparam int MODE_W = 2 * N_FLT;

  logic [N_PAIR_PINS-1:0] mask_pair;
  logic [N_SOLO_PINS-1:0] mask_solo;
  logic                   sw_pair, sw_solo;
  logic [MODE_W-1:0]      mode_q;
  logic                   cmp_en, osc_en, osc_flag;
  logic [PRESC_W-1:0]     presc;

  logic wr_mpair, wr_msolo, wr_sw, wr_mode, wr_fclr, wr_cmp, wr_osc, wr_presc;
  logic strobe;
  logic [N_FLT-1:0] flt_flag;
  logic cmp_flag;
  logic osc_hiz, flt_any, pair_src, solo_src;

  assign wr_mpair = wr_en && (wr_addr == A_MASK_PAIR);
  assign wr_msolo = wr_en && (wr_addr == A_MASK_SOLO);
  assign wr_sw    = wr_en && (wr_addr == A_SWREQ);
  assign wr_mode  = wr_en && (wr_addr == A_FLT_MODE);
  assign wr_fclr  = wr_en && (wr_addr == A_FLT_CLR);
  assign wr_cmp   = wr_en && (wr_addr == A_CMP);
  assign wr_osc   = wr_en && (wr_addr == A_OSC);
  assign wr_presc = wr_en && (wr_addr == A_PRESC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_pair <= '0;
      mask_solo <= '0;
      mode_q    <= '0;
      cmp_en    <= 1'b0;
      osc_en    <= 1'b1;
      presc     <= '0;
    end else begin
      if (wr_mpair) mask_pair <= wr_data[N_PAIR_PINS-1:0];
      if (wr_msolo) mask_solo <= wr_data[N_SOLO_PINS-1:0];
      if (wr_mode)  mode_q    <= wr_data[MODE_W-1:0];
      if (wr_cmp)   cmp_en    <= wr_data[0];
      if (wr_osc)   osc_en    <= wr_data[0];
      if (wr_presc) presc     <= wr_data[PRESC_W-1:0];
    end
  end

  // request bits and oscillator flag: hardware set beats software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_pair  <= 1'b0;
      sw_solo  <= 1'b0;
      osc_flag <= 1'b0;
    end else begin
      if (evt_pair)   sw_pair <= 1'b1;
      else if (wr_sw) sw_pair <= wr_data[0];
      if (evt_solo)   sw_solo <= 1'b1;
      else if (wr_sw) sw_solo <= wr_data[1];
      if (osc_stop)                  osc_flag <= 1'b1;
      else if (wr_osc && !wr_data[1]) osc_flag <= 1'b0;
    end
  end

  ptg_strobe #(.PW(PRESC_W)) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .presc  (presc),
    .strobe (strobe)
  );

  for (genvar k = 0; k < N_FLT; k++) begin : g_flt
    ptg_fault_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n    (flt_n[k]),
      .strobe   (strobe),
      .mode_raw (mode_q[2*k +: 2]),
      .clr_req  (wr_fclr && !wr_data[k]),
      .flag     (flt_flag[k])
    );
  end

  ptg_out_cmp #(.NP(N_PAIR_PINS)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cmp_en),
    .lvl     (pair_lvl),
    .clr_req (wr_cmp && !wr_data[1]),
    .flag    (cmp_flag)
  );

  assign osc_hiz  = osc_flag && osc_en;
  assign flt_any  = |flt_flag;
  assign pair_src = sw_pair || osc_hiz || flt_any || cmp_flag;
  assign solo_src = sw_solo || osc_hiz || flt_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tz_pair <= '0;
      tz_solo <= '0;
    end else begin
      tz_pair <= {N_PAIR_PINS{pair_src}} & mask_pair;
      tz_solo <= {N_SOLO_PINS{solo_src}} & mask_solo;
    end
  end

  // R1: no output on a pin that was unmasked
  p_mask_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((tz_pair & ~$past(mask_pair)) == '0));
  p_mask_solo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((tz_solo & ~$past(mask_solo)) == '0));

  // R4: an event always lands in its request bit
  p_evt_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pair |=> sw_pair);
  p_evt_solo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_solo |=> sw_solo);

  // R5: the flag holds while the stop indication persists
  p_osc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |=> osc_flag);

  // R10: the comparison flag alone never reaches the solo group
  p_solo_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !sw_solo && !osc_hiz && !flt_any) |=> (tz_solo == '0));

endmodule

// File: tb/pwm_tz_guard_tb.sv
module pwm_tz_guard_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic       evt_pair = 1'b0, evt_solo = 1'b0, osc_stop = 1'b0;
  logic [4:0] flt_n = 5'h1F;
  logic [5:0] pair_lvl = '0;
  logic [5:0] tz_pair;
  logic [3:0] tz_solo;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_tz_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .evt_pair(evt_pair), .evt_solo(evt_solo),
    .osc_stop(osc_stop), .flt_n(flt_n), .pair_lvl(pair_lvl),
    .tz_pair(tz_pair), .tz_solo(tz_solo)
  );

  // {mask_pair, mask_solo, req[1:0], expect_pair, expect_solo}
  localparam logic [21:0] VEC [8] = '{
    {6'h3F, 4'hF, 2'b00, 6'h00, 4'h0},
    {6'h3F, 4'hF, 2'b01, 6'h3F, 4'h0},
    {6'h3F, 4'hF, 2'b10, 6'h00, 4'hF},
    {6'h15, 4'h5, 2'b11, 6'h15, 4'h5},
    {6'h2A, 4'hA, 2'b01, 6'h2A, 4'h0},
    {6'h00, 4'hF, 2'b11, 6'h00, 4'hF},
    {6'h3F, 4'h0, 2'b11, 6'h3F, 4'h0},
    {6'h0C, 4'h3, 2'b10, 6'h00, 4'h3}
  };

  task automatic wr(input logic [2:0] a, input logic [9:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk(input string tag, input logic [5:0] ep, input logic [3:0] es);
    @(negedge clk);
    checks++;
    if (tz_pair !== ep || tz_solo !== es) begin
      failures++;
      $display("FAIL %s: tz_pair=%h tz_solo=%h expected %h %h",
               tag, tz_pair, tz_solo, ep, es);
    end
  endtask

  initial begin
    idle(200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1 rst_n = 1'b1;
    chk("R13 reset outputs", 6'h00, 4'h0);

    // table walk: masks and requests
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, {4'b0, VEC[i][21:16]});
      wr(3'd1, {6'b0, VEC[i][15:12]});
      wr(3'd2, {8'b0, VEC[i][11:10]});
      idle(2);
      chk($sformatf("R1 R2 R3 vector %0d", i), VEC[i][9:4], VEC[i][3:0]);
    end

    wr(3'd0, 10'h03F); wr(3'd1, 10'h00F); wr(3'd2, 10'h000);
    idle(2);
    chk("R2 R3 release", 6'h00, 4'h0);

    // R4 events
    @(posedge clk); #1 evt_pair = 1'b1;
    @(posedge clk); #1 evt_pair = 1'b0;
    idle(2);
    chk("R4 pair event", 6'h3F, 4'h0);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = '0; evt_solo = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; evt_solo = 1'b0;
    idle(2);
    chk("R4 event beats clear", 6'h00, 4'hF);
    wr(3'd2, 10'h000);
    idle(2);

    // R5 oscillator stop (enable is 1 from reset, R13)
    osc_stop = 1'b1;
    idle(3);
    chk("R5 R13 osc stop", 6'h3F, 4'hF);
    wr(3'd6, 10'b01);
    idle(2);
    chk("R5 clear while stop high", 6'h3F, 4'hF);
    osc_stop = 1'b0;
    wr(3'd6, 10'b01);
    idle(2);
    chk("R5 flag clear releases", 6'h00, 4'h0);
    osc_stop = 1'b1; idle(1); #1 osc_stop = 1'b0;
    idle(2);
    wr(3'd6, 10'b10);
    idle(2);
    chk("R5 enable clear releases", 6'h00, 4'h0);
    wr(3'd6, 10'b11);
    idle(2);
    chk("R5 enable reapplies flag", 6'h3F, 4'hF);
    wr(3'd6, 10'b01);
    idle(2);

    // R6 R8 edge mode faults
    flt_n[0] = 1'b0;
    idle(6);
    chk("R6 falling edge trip", 6'h3F, 4'hF);
    flt_n[0] = 1'b1;
    idle(4);
    wr(3'd4, 10'h3FE);
    idle(2);
    chk("R8 single flag cleared", 6'h00, 4'h0);
    flt_n[1] = 1'b0; flt_n[2] = 1'b0;
    idle(6);
    flt_n[1] = 1'b1; flt_n[2] = 1'b1;
    idle(4);
    wr(3'd4, 10'h3FD);
    idle(2);
    chk("R8 one of two cleared", 6'h3F, 4'hF);
    wr(3'd4, 10'h3FB);
    idle(2);
    chk("R8 last flag cleared", 6'h00, 4'h0);

    // R7 R12 R9: eight-sample mode with divider 10
    wr(3'd7, 10'd9);
    wr(3'd3, 10'h040);
    flt_n[3] = 1'b0; idle(50); #1 flt_n[3] = 1'b1;
    idle(40);
    chk("R7 short low run ignored", 6'h00, 4'h0);
    flt_n[3] = 1'b0; idle(55);
    chk("R12 not yet tripped at slow strobe", 6'h00, 4'h0);
    idle(65);
    chk("R7 R12 eight samples trip", 6'h3F, 4'hF);
    wr(3'd4, 10'h3F7);
    idle(2);
    chk("R9 clear refused while low", 6'h3F, 4'hF);
    @(posedge clk); #1 flt_n[3] = 1'b1;
    wr(3'd4, 10'h3F7);
    idle(2);
    chk("R9 clear refused before high sampled", 6'h3F, 4'hF);
    idle(30);
    wr(3'd4, 10'h3F7);
    idle(2);
    chk("R9 clear accepted after high sample", 6'h00, 4'h0);

    // R7 sixteen and 128 sample modes, divider 1
    wr(3'd7, 10'd0);
    wr(3'd3, 10'h320);
    flt_n[2] = 1'b0; idle(12); #1 flt_n[2] = 1'b1;
    idle(6);
    chk("R7 sixteen-sample short run", 6'h00, 4'h0);
    flt_n[2] = 1'b0; idle(25);
    chk("R7 sixteen samples trip", 6'h3F, 4'hF);
    flt_n[2] = 1'b1; idle(5);
    wr(3'd4, 10'h3FB);
    idle(2);
    chk("R8 sixteen-sample flag cleared", 6'h00, 4'h0);
    flt_n[4] = 1'b0; idle(100);
    chk("R7 128 mode at 100 samples", 6'h00, 4'h0);
    idle(40);
    chk("R7 128 samples trip", 6'h3F, 4'hF);
    flt_n[4] = 1'b1; idle(5);
    wr(3'd4, 10'h3EF);
    idle(2);
    chk("R8 128-sample flag cleared", 6'h00, 4'h0);

    // R10 R11 output comparison
    wr(3'd5, 10'b01);
    pair_lvl = 6'b000101;
    idle(3);
    chk("R10 no pair clash", 6'h00, 4'h0);
    pair_lvl = 6'b001100;
    idle(3);
    chk("R10 clash pair group only", 6'h3F, 4'h0);
    pair_lvl = 6'b000100;
    wr(3'd5, 10'b01);
    idle(2);
    chk("R11 clear refused while active", 6'h3F, 4'h0);
    pair_lvl = 6'b000000;
    wr(3'd5, 10'b01);
    idle(2);
    chk("R11 clear accepted when idle", 6'h00, 4'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule